// File: doc/BRIEF.md
# Load/Store Exception Priority Resolver

This block looks at one data memory access per cycle and reports the single synchronous exception that wins among the faults that access could raise, together with its 4-bit cause code and the virtual address that faulted. The access is described by a valid strobe, a store/AMO-versus-load flag, the virtual address and a size code. Four side-band flags come from the neighbouring translation and protection logic: address-breakpoint match, translation page fault, physical-protection access fault, and whether the translated physical region accepts misaligned accesses. The result is registered and shows up one clock after the strobe.

A build-time parameter, `MISALIGN_LAST`, places the misaligned check. With the value 0 it sits just below the breakpoint and fires regardless of translation and protection results. This suits a core that never performs misaligned accesses. With the value 1 the access is translated and checked first. A misaligned access then faults only if no page or access fault exists and the target region refuses misaligned access. Environment call and break are resolved upstream and never reach this block.

Top module: `ls_exc_resolver`

## Requirements
- R1: While reset is held, and until the first access after reset, `exc_valid`, `exc_cause` and `exc_addr` are all zero.
- R2: Outputs are registered. The result for an access sampled with `acc_valid` high appears on the next clock. A cycle with `acc_valid` low gives all-zero outputs on the next clock, whatever the other inputs are.
- R3: `acc_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. An access is misaligned when the address is not a multiple of its size (bit 0 for 2 bytes, bits 1:0 for 4 bytes, bits 2:0 for 8 bytes), and a 1-byte access is never misaligned.
- R4: An address-breakpoint match outranks every other fault in both modes and reports cause 3.
- R5: With `MISALIGN_LAST`=0 the order is breakpoint, misaligned, page fault, access fault.
- R6: With `MISALIGN_LAST`=0, `region_misal_ok` has no effect on any output.
- R7: With `MISALIGN_LAST`=1 the order is breakpoint, page fault, access fault, misaligned.
- R8: With `MISALIGN_LAST`=1 a misaligned access faults as misaligned only when `region_misal_ok` is low.
- R9: Cause codes follow `acc_is_store` (1 = store/AMO, 0 = load): misaligned 6/4, page fault 15/13, access fault 7/5.
- R10: When an exception is reported, `exc_addr` equals the access's virtual address. Otherwise it is zero.
- R11: When no exception applies, `exc_valid` is low and `exc_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_is_store | input | 1 | 1 = store/AMO, 0 = load |
| acc_addr | input | ADDR_W | Virtual address of the access |
| acc_size | input | 2 | Size code: 0/1/2/3 = 1/2/4/8 bytes |
| bkpt_hit | input | 1 | Address breakpoint matched |
| xlate_pf | input | 1 | Translation reported a page fault |
| prot_af | input | 1 | Physical protection reported an access fault |
| region_misal_ok | input | 1 | Translated region accepts misaligned accesses |
| exc_valid | output | 1 | An exception is reported |
| exc_cause | output | 4 | Cause code of the winning exception, 0 if none |
| exc_addr | output | ADDR_W | Faulting virtual address, 0 if none |

## Verification
A priority chain wired in the wrong order would not hang the block. It would report a legal but wrong cause on the very next clock after an access that raises two faults together. The bench therefore drives every combination of size, low address bits and fault flags, for both kinds of access, into both mode variants. It compares each registered result one cycle later. A misalignment mask off by one bit shows up on the first access of that size with its top offset bit set. A stale output register shows up as a non-zero result in the cycle after an idle strobe.

// File: rtl/ls_exc_pkg.sv
package ls_exc_pkg;

  localparam int CAUSE_W   = 4;
  localparam int MAX_BYTES = 8;
  localparam int OFFS_W    = $clog2(MAX_BYTES);
  localparam int SIZE_W    = $clog2(OFFS_W + 1);

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE   = 4'd0;
  localparam cause_t CAUSE_BKPT   = 4'd3;
  localparam cause_t CAUSE_LD_MIS = 4'd4;
  localparam cause_t CAUSE_LD_AF  = 4'd5;
  localparam cause_t CAUSE_ST_MIS = 4'd6;
  localparam cause_t CAUSE_ST_AF  = 4'd7;
  localparam cause_t CAUSE_LD_PF  = 4'd13;
  localparam cause_t CAUSE_ST_PF  = 4'd15;

  function automatic cause_t by_kind(input logic is_store, input cause_t st_code,
                                     input cause_t ld_code);
    return is_store ? st_code : ld_code;
  endfunction

endpackage

// File: rtl/ls_rst_sync.sv
module ls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ls_align_check.sv
module ls_align_check
  import ls_exc_pkg::*;
(
  input  logic [SIZE_W-1:0] size_code,
  input  logic [OFFS_W-1:0] addr_lo,
  output logic              misaligned
);

  logic [OFFS_W-1:0] offs_mask;

  for (genvar g = 0; g < OFFS_W; g++) begin : g_mask
    assign offs_mask[g] = (size_code > SIZE_W'(g));
  end

  assign misaligned = |(addr_lo & offs_mask);

endmodule

// File: rtl/ls_fault_select.sv
module ls_fault_select
  import ls_exc_pkg::*;
#(
  parameter bit MISALIGN_LAST = 1'b0
) (
  input  logic   is_store,
  input  logic   misaligned,
  input  logic   bkpt_hit,
  input  logic   xlate_pf,
  input  logic   prot_af,
  input  logic   region_misal_ok,
  output logic   hit,
  output cause_t cause
);

  cause_t mis_code, pf_code, af_code;
  logic   mis_fault;

  assign mis_code = by_kind(is_store, CAUSE_ST_MIS, CAUSE_LD_MIS);
  assign pf_code  = by_kind(is_store, CAUSE_ST_PF,  CAUSE_LD_PF);
  assign af_code  = by_kind(is_store, CAUSE_ST_AF,  CAUSE_LD_AF);

  // Region support only gates the fault when the check runs after translation.
  assign mis_fault = misaligned & (~region_misal_ok | ~MISALIGN_LAST);

  if (MISALIGN_LAST) begin : g_mis_last
    always_comb begin
      if (bkpt_hit)       cause = CAUSE_BKPT;
      else if (xlate_pf)  cause = pf_code;
      else if (prot_af)   cause = af_code;
      else if (mis_fault) cause = mis_code;
      else                cause = CAUSE_NONE;
    end
  end else begin : g_mis_first
    always_comb begin
      if (bkpt_hit)       cause = CAUSE_BKPT;
      else if (mis_fault) cause = mis_code;
      else if (xlate_pf)  cause = pf_code;
      else if (prot_af)   cause = af_code;
      else                cause = CAUSE_NONE;
    end
  end

  assign hit = bkpt_hit | mis_fault | xlate_pf | prot_af;

endmodule

// File: rtl/ls_exc_resolver.sv
module ls_exc_resolver
  import ls_exc_pkg::*;
#(
  parameter int ADDR_W        = 64,
  parameter bit MISALIGN_LAST = 1'b0,
  parameter int RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              bkpt_hit,
  input  logic              xlate_pf,
  input  logic              prot_af,
  input  logic              region_misal_ok,
  output logic              exc_valid,
  output logic [3:0]        exc_cause,
  output logic [ADDR_W-1:0] exc_addr
);

  logic   rst_sync_n;
  logic   misaligned;
  logic   sel_hit;
  cause_t sel_cause;

  logic              valid_d, valid_q;
  cause_t            cause_d, cause_q;
  logic [ADDR_W-1:0] addr_d,  addr_q;
  logic              upd_en;

  ls_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  ls_align_check u_align (
    .size_code (acc_size),
    .addr_lo   (acc_addr[OFFS_W-1:0]),
    .misaligned(misaligned)
  );

  ls_fault_select #(.MISALIGN_LAST(MISALIGN_LAST)) u_sel (
    .is_store       (acc_is_store),
    .misaligned     (misaligned),
    .bkpt_hit       (bkpt_hit),
    .xlate_pf       (xlate_pf),
    .prot_af        (prot_af),
    .region_misal_ok(region_misal_ok),
    .hit            (sel_hit),
    .cause          (sel_cause)
  );

  // Next state: load a new result on a strobe, clear a stale one otherwise.
  always_comb begin
    upd_en  = acc_valid | valid_q;
    valid_d = acc_valid & sel_hit;
    cause_d = valid_d ? sel_cause : CAUSE_NONE;
    addr_d  = valid_d ? acc_addr  : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      addr_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      cause_q <= cause_d;
      addr_q  <= addr_d;
    end
  end

  assign exc_valid = valid_q;
  assign exc_cause = cause_q;
  assign exc_addr  = addr_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (!exc_valid && exc_cause == CAUSE_NONE));

  // R2
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |=> (!exc_valid && exc_cause == CAUSE_NONE && exc_addr == '0));

  // R4
  bkpt_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_valid && bkpt_hit) |=> (exc_valid && exc_cause == CAUSE_BKPT));

  // R10
  addr_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_valid |-> exc_addr == $past(acc_addr));

  // R11
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exc_valid |-> (exc_cause == CAUSE_NONE && exc_addr == '0));

  if (MISALIGN_LAST) begin : g_chk_last
    // R8
    region_ok_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (acc_valid && region_misal_ok && !bkpt_hit && !xlate_pf && !prot_af)
        |=> !exc_valid);
    // R7
    pf_over_mis_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (acc_valid && !bkpt_hit && xlate_pf)
        |=> exc_cause == by_kind($past(acc_is_store), CAUSE_ST_PF, CAUSE_LD_PF));
  end else begin : g_chk_first
    // R6
    mis_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (acc_valid && misaligned && !bkpt_hit)
        |=> (exc_valid &&
             exc_cause == by_kind($past(acc_is_store), CAUSE_ST_MIS, CAUSE_LD_MIS)));
  end

endmodule

// File: tb/tb_ls_exc_resolver.sv
`timescale 1ns/1ps
module tb_ls_exc_resolver;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_is_store = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic          bkpt_hit = 1'b0, xlate_pf = 1'b0, prot_af = 1'b0, region_misal_ok = 1'b0;

  logic          v0, v1;
  logic [3:0]    c0, c1;
  logic [AW-1:0] a0, a1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ls_exc_resolver #(.ADDR_W(AW), .MISALIGN_LAST(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_addr(acc_addr), .acc_size(acc_size), .bkpt_hit(bkpt_hit), .xlate_pf(xlate_pf),
    .prot_af(prot_af), .region_misal_ok(region_misal_ok),
    .exc_valid(v0), .exc_cause(c0), .exc_addr(a0)
  );

  ls_exc_resolver #(.ADDR_W(AW), .MISALIGN_LAST(1'b1)) dut_last (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_addr(acc_addr), .acc_size(acc_size), .bkpt_hit(bkpt_hit), .xlate_pf(xlate_pf),
    .prot_af(prot_af), .region_misal_ok(region_misal_ok),
    .exc_valid(v1), .exc_cause(c1), .exc_addr(a1)
  );

  task automatic check(input string tag, input logic gv, input logic [3:0] gc,
                       input logic [AW-1:0] ga, input logic ev, input logic [3:0] ec,
                       input logic [AW-1:0] ea);
    checks++;
    if (gv !== ev || gc !== ec || ga !== ea) begin
      errors++;
      $display("FAIL %s: got v=%0b cause=%0d addr=%h, expected v=%0b cause=%0d addr=%h",
               tag, gv, gc, ga, ev, ec, ea);
    end
  endtask

  // Reference priority, computed from the requirement text.
  task automatic model(input bit last, input bit st, input int sz, input int lo,
                       input bit bk, input bit pf, input bit af, input bit ok,
                       output logic [3:0] c, output string tag);
    bit mis;
    mis = (lo % (1 << sz)) != 0;                      // R3
    if (bk) begin c = 4'd3; tag = "R4"; end
    else if (!last) begin
      if (mis)     begin c = st ? 4'd6 : 4'd4;   tag = "R3/R5/R6/R9"; end
      else if (pf) begin c = st ? 4'd15 : 4'd13; tag = "R5/R9"; end
      else if (af) begin c = st ? 4'd7 : 4'd5;   tag = "R5/R9"; end
      else         begin c = 4'd0;               tag = "R11/R6"; end
    end else begin
      if (pf)             begin c = st ? 4'd15 : 4'd13; tag = "R7/R9"; end
      else if (af)        begin c = st ? 4'd7 : 4'd5;   tag = "R7/R9"; end
      else if (mis && !ok) begin c = st ? 4'd6 : 4'd4;  tag = "R3/R7/R8"; end
      else if (mis)       begin c = 4'd0;               tag = "R8/R11"; end
      else                begin c = 4'd0;               tag = "R11"; end
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0]    ec;
    logic [AW-1:0] addr;
    string         tag;

    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    check("R1", v0, c0, a0, 1'b0, 4'd0, '0);
    check("R1", v1, c1, a1, 1'b0, 4'd0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", v0, c0, a0, 1'b0, 4'd0, '0);
    check("R1", v1, c1, a1, 1'b0, 4'd0, '0);

    for (int st = 0; st < 2; st++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int lo = 0; lo < 8; lo++) begin
          for (int fl = 0; fl < 16; fl++) begin
            addr            = AW'(16'hA5A0 ^ ((st * 4 + sz) << 9) ^ (fl << 4)) | AW'(lo);
            acc_valid       = 1'b1;
            acc_is_store    = st[0];
            acc_size        = 2'(sz);
            acc_addr        = addr;
            bkpt_hit        = fl[3];
            xlate_pf        = fl[2];
            prot_af         = fl[1];
            region_misal_ok = fl[0];
            @(negedge clk);
            model(1'b0, st[0], sz, lo, fl[3], fl[2], fl[1], fl[0], ec, tag);
            // R10: address reported only with an exception
            check({tag, "/R10"}, v0, c0, a0, ec != 0, ec, (ec != 0) ? addr : '0);
            model(1'b1, st[0], sz, lo, fl[3], fl[2], fl[1], fl[0], ec, tag);
            check({tag, "/R10"}, v1, c1, a1, ec != 0, ec, (ec != 0) ? addr : '0);
          end
        end
      end
    end

    // R2: a strobe-low cycle with every fault flag set clears the outputs
    acc_valid = 1'b1; bkpt_hit = 1'b1;
    @(negedge clk);
    check("R2", v0, c0, a0, 1'b1, 4'd3, acc_addr);
    acc_valid = 1'b0; xlate_pf = 1'b1; prot_af = 1'b1; acc_size = 2'd3; acc_addr = 16'h0007;
    @(negedge clk);
    check("R2", v0, c0, a0, 1'b0, 4'd0, '0);
    check("R2", v1, c1, a1, 1'b0, 4'd0, '0);
    @(negedge clk);
    check("R2", v0, c0, a0, 1'b0, 4'd0, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule